// File: doc/BRIEF.md
# Three-Wire Potentiometer Host Sequencer

This block sits on the host side of a digital potentiometer that is moved by three control pins: an active-low select, a falling-edge-counted increment strobe and a direction level. A single command, accepted through a start/ready handshake, gives a step count, a direction and a commit flag. The sequencer selects the part, produces exactly that many increment pulses, and then deselects it. If commit is set, the increment pin is left high at deselect, so the part stores the position. If commit is clear, the increment pin is left low at deselect, so the part drops the store.

Every minimum interval between pin transitions is a parameter in nanoseconds. Each one is converted to clock cycles by rounding up against a clock-period parameter, so no interval is ever shorter than its specification. The select setup, direction setup and strobe high time all have to pass before the first falling strobe, so one setup phase covers all three. The high phase between pulses is stretched until a full strobe period is also met. After a store deselect, the block stays busy for the long commit wait before it accepts the next command.

Top module: `dcp_step_master`

## Requirements
- R1: Out of reset and whenever idle, `sel_n_o` = 1, `inc_o` = 1 and `cmd_ready` = 1. Out of reset, `dir_o` = 1 (up).
- R2: A command accepted while `cmd_ready` = 1 (with steps > 0 or commit = 1) has the following effect on the next cycle: `cmd_ready` = 0, `sel_n_o` = 0, `inc_o` = 1 and `dir_o` = requested direction. These levels hold for C_SU = max(select setup, direction setup, strobe high) cycles.
- R3: Each step is one `inc_o` low phase of C_IL cycles. Consecutive low phases are separated by a high phase of C_HI = max(strobe high, strobe period − C_IL, strobe-to-deselect) cycles. The number of falling `inc_o` edges equals the step count, and every one occurs while `sel_n_o` = 0.
- R4: `dir_o` changes only on the cycle a command is accepted. It is constant while `sel_n_o` = 0 and afterwards.
- R5: With commit = 1, after the last low phase `inc_o` rises for C_HI cycles. Then `sel_n_o` rises with `inc_o` = 1, and `cmd_ready` returns after C_ST (store wait) cycles.
- R6: With commit = 0, `sel_n_o` rises directly after the last low phase while `inc_o` = 0. After C_NS cycles, `inc_o` rises. `cmd_ready` returns C_ID (direction hold) cycles after that.
- R7: Steps = 0 with commit = 1 gives a setup phase and then the store deselect, with no `inc_o` edge.
- R8: Steps = 0 with commit = 0 drives no pin and leaves `cmd_ready` = 1.
- R9: `cmd_start` while `cmd_ready` = 0 has no effect on the pin sequence in progress.
- R10: Every interval in cycles is ceil(ns × 1000 / CLK_PERIOD_PS), and never less than 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_start | input | 1 | Command request, taken when cmd_ready is 1 |
| cmd_ready | output | 1 | Idle, able to take a command |
| cmd_steps | input | STEP_W | Number of increment pulses |
| cmd_dir_up | input | 1 | 1 = move up, 0 = move down |
| cmd_commit | input | 1 | 1 = store the position at deselect |
| sel_n_o | output | 1 | Potentiometer select, active low |
| inc_o | output | 1 | Increment strobe, counted on falling edge |
| dir_o | output | 1 | Direction level to the potentiometer |

## Verification
The bench targets the following corner cases:
- The last step with and without commit. A design that dropped the trailing high phase before a store, or raised the strobe before a skip-store deselect, would store when it should not, or the reverse.
- Zero-step commands. A wrong design would emit a stray falling strobe, which the part counts as a step, or would wake the pins for a command that asks for nothing.
- Commands issued while busy, with a different count, direction and commit. A design that re-latched them would change the pulse count or flip direction mid-selection.
- Interval lengths, compared cycle for cycle. An interval rounded down or truncated to the wrong width shows up as a pin edge one or more cycles early.

// File: rtl/dcp_seq_pkg.sv
package dcp_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_LOW,
        ST_HIGH,
        ST_REL_STORE,
        ST_REL_SKIP,
        ST_RECOVER
    } seq_state_e;

    typedef struct packed {
        seq_state_e state;
        logic       sel_n;
        logic       inc;
        logic       dir;
        logic       commit;
    } seq_regs_t;

    // R10: round every interval up to whole cycles, at least one
    function automatic int unsigned ns_to_cycles(input int unsigned ns,
                                                 input int unsigned period_ps);
        longint unsigned num;
        longint unsigned cyc;
        num = 64'(ns) * 64'd1000 + 64'(period_ps) - 64'd1;
        cyc = num / 64'(period_ps);
        if (cyc == 64'd0) cyc = 64'd1;
        return 32'(cyc);
    endfunction

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/dcp_interval_timer.sv
module dcp_interval_timer #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    output logic         expired_o
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)
            cnt_d = load_val_i;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired_o = (cnt_q == '0);

    // R3
    hold_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && cnt_q == '0) |=> (cnt_q == '0));

endmodule

// File: rtl/dcp_step_counter.sv
module dcp_step_counter #(
    parameter int unsigned W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    input  logic         dec_i,
    output logic         zero_o
);
    logic [W-1:0] left_d, left_q;

    always_comb begin
        left_d = left_q;
        if (load_i)
            left_d = load_val_i;
        else if (dec_i)
            left_d = left_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) left_q <= '0;
        else        left_q <= left_d;
    end

    assign zero_o = (left_q == '0);

    // R3
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec_i |-> (left_q != '0));

endmodule

// File: rtl/dcp_step_master.sv
module dcp_step_master
    import dcp_seq_pkg::*;
#(
    parameter int unsigned CLK_PERIOD_PS   = 8000,
    parameter int unsigned STEP_W          = 7,
    parameter int unsigned SEL_SETUP_NS    = 100,
    parameter int unsigned DIR_SETUP_NS    = 1000,
    parameter int unsigned DIR_HOLD_NS     = 100,
    parameter int unsigned INC_LOW_NS      = 1000,
    parameter int unsigned INC_HIGH_NS     = 1000,
    parameter int unsigned INC_PERIOD_NS   = 4000,
    parameter int unsigned INC_TO_DESEL_NS = 1000,
    parameter int unsigned STORE_WAIT_NS   = 20000000,
    parameter int unsigned SKIP_WAIT_NS    = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_start,
    output logic              cmd_ready,
    input  logic [STEP_W-1:0] cmd_steps,
    input  logic              cmd_dir_up,
    input  logic              cmd_commit,
    output logic              sel_n_o,
    output logic              inc_o,
    output logic              dir_o
);
    // R10: cycle counts, each rounded up
    localparam int unsigned C_CI  = ns_to_cycles(SEL_SETUP_NS,    CLK_PERIOD_PS);
    localparam int unsigned C_DI  = ns_to_cycles(DIR_SETUP_NS,    CLK_PERIOD_PS);
    localparam int unsigned C_ID  = ns_to_cycles(DIR_HOLD_NS,     CLK_PERIOD_PS);
    localparam int unsigned C_IL  = ns_to_cycles(INC_LOW_NS,      CLK_PERIOD_PS);
    localparam int unsigned C_IH  = ns_to_cycles(INC_HIGH_NS,     CLK_PERIOD_PS);
    localparam int unsigned C_CYC = ns_to_cycles(INC_PERIOD_NS,   CLK_PERIOD_PS);
    localparam int unsigned C_IC  = ns_to_cycles(INC_TO_DESEL_NS, CLK_PERIOD_PS);
    localparam int unsigned C_ST  = ns_to_cycles(STORE_WAIT_NS,   CLK_PERIOD_PS);
    localparam int unsigned C_NS  = ns_to_cycles(SKIP_WAIT_NS,    CLK_PERIOD_PS);

    localparam int unsigned C_SU  = max2(max2(C_CI, C_DI), C_IH);
    localparam int unsigned C_PAD = (C_CYC > C_IL) ? (C_CYC - C_IL) : 1;
    localparam int unsigned C_HI  = max2(max2(C_IH, C_PAD), C_IC);

    localparam int unsigned C_MAX = max2(max2(max2(C_SU, C_HI), max2(C_IL, C_ST)),
                                         max2(C_NS, C_ID));
    localparam int unsigned TMR_W = $clog2(C_MAX + 1);

    localparam logic [TMR_W-1:0] L_SU = TMR_W'(C_SU - 1);
    localparam logic [TMR_W-1:0] L_IL = TMR_W'(C_IL - 1);
    localparam logic [TMR_W-1:0] L_HI = TMR_W'(C_HI - 1);
    localparam logic [TMR_W-1:0] L_ST = TMR_W'(C_ST - 1);
    localparam logic [TMR_W-1:0] L_NS = TMR_W'(C_NS - 1);
    localparam logic [TMR_W-1:0] L_ID = TMR_W'(C_ID - 1);

    seq_regs_t r_d, r_q;

    logic             tmr_load;
    logic [TMR_W-1:0] tmr_val;
    logic             tmr_done;
    logic             cnt_load;
    logic             cnt_dec;
    logic             cnt_zero;
    logic             accept;

    dcp_interval_timer #(.W(TMR_W)) tmr_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .expired_o  (tmr_done)
    );

    dcp_step_counter #(.W(STEP_W)) cnt_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (cnt_load),
        .load_val_i (cmd_steps),
        .dec_i      (cnt_dec),
        .zero_o     (cnt_zero)
    );

    assign accept = cmd_start && (r_q.state == ST_IDLE);

    always_comb begin
        r_d      = r_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        cnt_load = 1'b0;
        cnt_dec  = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                // R8: an empty command without commit touches nothing
                if (accept && (cmd_steps != '0 || cmd_commit)) begin
                    r_d.state  = ST_SETUP;
                    r_d.sel_n  = 1'b0;
                    r_d.inc    = 1'b1;
                    r_d.dir    = cmd_dir_up;
                    r_d.commit = cmd_commit;
                    cnt_load   = 1'b1;
                    tmr_load   = 1'b1;
                    tmr_val    = L_SU;
                end
            end
            ST_SETUP: begin
                if (tmr_done) begin
                    tmr_load = 1'b1;
                    if (cnt_zero) begin
                        r_d.state = ST_REL_STORE;
                        r_d.sel_n = 1'b1;
                        tmr_val   = L_ST;
                    end else begin
                        r_d.state = ST_LOW;
                        r_d.inc   = 1'b0;
                        cnt_dec   = 1'b1;
                        tmr_val   = L_IL;
                    end
                end
            end
            ST_LOW: begin
                if (tmr_done) begin
                    tmr_load = 1'b1;
                    if (cnt_zero && !r_q.commit) begin
                        r_d.state = ST_REL_SKIP;
                        r_d.sel_n = 1'b1;
                        tmr_val   = L_NS;
                    end else begin
                        r_d.state = ST_HIGH;
                        r_d.inc   = 1'b1;
                        tmr_val   = L_HI;
                    end
                end
            end
            ST_HIGH: begin
                if (tmr_done) begin
                    tmr_load = 1'b1;
                    if (cnt_zero) begin
                        r_d.state = ST_REL_STORE;
                        r_d.sel_n = 1'b1;
                        tmr_val   = L_ST;
                    end else begin
                        r_d.state = ST_LOW;
                        r_d.inc   = 1'b0;
                        cnt_dec   = 1'b1;
                        tmr_val   = L_IL;
                    end
                end
            end
            ST_REL_STORE: begin
                if (tmr_done) r_d.state = ST_IDLE;
            end
            ST_REL_SKIP: begin
                if (tmr_done) begin
                    r_d.state = ST_RECOVER;
                    r_d.inc   = 1'b1;
                    tmr_load  = 1'b1;
                    tmr_val   = L_ID;
                end
            end
            ST_RECOVER: begin
                if (tmr_done) r_d.state = ST_IDLE;
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.state  <= ST_IDLE;
            r_q.sel_n  <= 1'b1;
            r_q.inc    <= 1'b1;
            r_q.dir    <= 1'b1;
            r_q.commit <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign cmd_ready = (r_q.state == ST_IDLE);
    assign sel_n_o   = r_q.sel_n;
    assign inc_o     = r_q.inc;
    assign dir_o     = r_q.dir;

    // R2
    select_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_ready && cmd_start && (cmd_steps != '0 || cmd_commit))
        |=> (!cmd_ready && !sel_n_o && inc_o && dir_o == $past(cmd_dir_up)));

    // R3
    strobe_fall_selected_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(inc_o) |-> !sel_n_o);

    // R4
    dir_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_ready && $past(!cmd_ready)) |-> $stable(dir_o));

    // R5
    // R6
    deselect_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sel_n_o) |-> (inc_o == r_q.commit));

    // R8
    empty_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_ready && cmd_start && cmd_steps == '0 && !cmd_commit)
        |=> (cmd_ready && sel_n_o && inc_o));

    // R9
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_ready |=> $stable(r_q.commit));

endmodule

// File: tb/dcp_step_master_tb.sv
module dcp_step_master_tb_top;

    localparam int unsigned PERIOD_PS = 8000;
    localparam int unsigned STORE_NS  = 20000;

    // R10: independent ceil conversion
    function automatic int cyc_of(input int ns);
        return (ns * 1000 + PERIOD_PS - 1) / PERIOD_PS;
    endfunction

    localparam int C_SU = 125;  // max(100 ns -> 13, 1 us -> 125, 1 us -> 125)
    localparam int C_IL = 125;
    localparam int C_HI = 375;  // 4 us period minus 125 low
    localparam int C_ST = 2500; // 20 us store wait
    localparam int C_NS = 125;
    localparam int C_ID = 13;   // 100 ns rounded up from 12.5

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_start = 1'b0;
    logic [6:0] cmd_steps = '0;
    logic       cmd_dir_up = 1'b0;
    logic       cmd_commit = 1'b0;
    logic       cmd_ready, sel_n_o, inc_o, dir_o;

    int  checks = 0;
    int  fails  = 0;
    int  cyc    = 0;
    int  poke_at = -1;
    logic last_dir = 1'b1;
    bit  done = 1'b0;

    always #4 clk = ~clk;

    dcp_step_master #(
        .CLK_PERIOD_PS (PERIOD_PS),
        .STORE_WAIT_NS (STORE_NS)
    ) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_start  (cmd_start),
        .cmd_ready  (cmd_ready),
        .cmd_steps  (cmd_steps),
        .cmd_dir_up (cmd_dir_up),
        .cmd_commit (cmd_commit),
        .sel_n_o    (sel_n_o),
        .inc_o      (inc_o),
        .dir_o      (dir_o)
    );

    task automatic chk(input logic act, input logic exp, input string tag, input string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%b expected=%b cycle=%0d", tag, what, act, exp, cyc);
        end
    endtask

    task automatic expect_run(input int n, input logic sel, input logic inc,
                              input logic dir, input logic rdy, input string tag);
        string t;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            cyc++;
            t = (poke_at >= 0) ? {tag, "/R9"} : tag;
            chk(sel_n_o,   sel, t, "sel_n");
            chk(inc_o,     inc, t, "inc");
            chk(cmd_ready, rdy, t, "ready");
            chk(dir_o,     dir, "R4", "dir");
            if (cyc == 1) cmd_start = 1'b0;
            if (poke_at >= 0 && cyc == poke_at) begin
                cmd_start  = 1'b1;
                cmd_steps  = 7'd7;
                cmd_dir_up = ~cmd_dir_up;
                cmd_commit = ~cmd_commit;
            end
            if (poke_at >= 0 && cyc == poke_at + 1) cmd_start = 1'b0;
        end
    endtask

    task automatic run_cmd(input int steps, input logic dir, input logic commit, input int poke);
        @(negedge clk);
        cmd_steps  = 7'(steps);
        cmd_dir_up = dir;
        cmd_commit = commit;
        cmd_start  = 1'b1;
        cyc        = 0;
        poke_at    = poke;
        if (steps == 0 && !commit) begin
            expect_run(20, 1'b1, 1'b1, last_dir, 1'b1, "R8");
        end else begin
            expect_run(C_SU, 1'b0, 1'b1, dir, 1'b0, (steps == 0) ? "R7" : "R2");
            for (int s = 0; s < steps; s++) begin
                expect_run(C_IL, 1'b0, 1'b0, dir, 1'b0, "R3");
                if (s < steps - 1 || commit)
                    expect_run(C_HI, 1'b0, 1'b1, dir, 1'b0, "R3");
            end
            if (commit) begin
                expect_run(C_ST, 1'b1, 1'b1, dir, 1'b0, (steps == 0) ? "R7" : "R5");
            end else begin
                expect_run(C_NS, 1'b1, 1'b0, dir, 1'b0, "R6");
                expect_run(C_ID, 1'b1, 1'b1, dir, 1'b0, "R6");
            end
            last_dir = dir;
            poke_at  = -1;
            expect_run(4, 1'b1, 1'b1, dir, 1'b1, "R1");
        end
        poke_at = -1;
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin : stim
        // R10: bench constants agree with the rounding rule
        checks++;
        if (cyc_of(100) != C_ID || cyc_of(1000) != C_IL || cyc_of(4000) - C_IL != C_HI
            || cyc_of(20000) != C_ST) begin
            fails++;
            $display("FAIL R10 constant mismatch actual=%0d expected=%0d", cyc_of(100), C_ID);
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(sel_n_o,   1'b1, "R1", "sel_n in reset");
        chk(inc_o,     1'b1, "R1", "inc in reset");
        chk(cmd_ready, 1'b1, "R1", "ready in reset");
        chk(dir_o,     1'b1, "R1", "dir in reset");
        rst_n = 1'b1;
        expect_run(5, 1'b1, 1'b1, 1'b1, 1'b1, "R1");

        run_cmd(3, 1'b1, 1'b1, -1);
        run_cmd(2, 1'b0, 1'b0, -1);
        run_cmd(0, 1'b1, 1'b1, -1);
        run_cmd(0, 1'b0, 1'b0, -1);
        run_cmd(5, 1'b0, 1'b0, 300);
        run_cmd(1, 1'b1, 1'b1, 60);
        run_cmd(1, 1'b0, 1'b0, 2600);
        run_cmd(4, 1'b1, 1'b1, 10);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule